// File: doc/BRIEF.md
# Two-Wire Link Escape and Activation Detector

This block watches a two-wire debug link made of a link clock and a data line. The data line is observed here as an input only. Both lines pass through two-flop synchronizers into the system clock. Edges are detected on the synchronized copies.

Toggles of the data line while the link clock is held high form an escape sequence. The number of toggles is judged at the next rising link-clock edge:
- A long escape returns the link to standard four-wire operation.
- An escape of exactly six toggles starts an online activation sequence.

During activation, an internal bit pointer advances on every rising link-clock edge, and the block reports which activation field is currently being clocked. The activation code is 12 bits long. It grows to 36 bits when the data line is sampled low on the rising edge that brings the pointer to 8. Once the pointer passes the code length, the link enters the three-phase serial scan mode, and a one-cycle pulse drives the attached TAP controller into Test-Logic-Reset.

The controller has four named states:
- `ST_FOUR_WIRE`: idle, standard wiring.
- `ST_ACT_SHORT`: activation with the 12-bit length.
- `ST_ACT_LONG`: activation with the 36-bit length.
- `ST_SERIAL3`: serial scan mode.

Its transitions, all taken only on a synchronized rising link-clock edge, are:
- **escape-four** (any state to `ST_FOUR_WIRE`).
- **escape-activate** (any state to `ST_ACT_SHORT`, pointer restarts at 1).
- **advance** (pointer plus one, same state).
- **extend** (`ST_ACT_SHORT` to `ST_ACT_LONG`).
- **complete** (either activation state to `ST_SERIAL3`, with the reset pulse).

Top module: `link_escape_detect`

## Requirements
- R1: A synchronous reset, whether at start-up or in the middle of an activation, gives mode 0 (four-wire), field code 0 and no TAP reset pulse.
- R2: Data-line toggles are counted only while the synchronized link clock is high. The count is judged and cleared at the next rising link-clock edge. Toggles made while the link clock is low are not counted.
- R3: A count of 8 or more at a rising edge forces mode 0 from any mode.
- R4: A count of exactly 6 at a rising edge gives mode 1 (activation) with the pointer at 1, which is field code 1, from any mode.
- R5: Counts of 1 to 5, or of 7, leave mode and field unchanged apart from normal pointer advance.
- R6: In 12-bit activation, the field code follows the pointer value p as follows: p 1..4 gives 1 (opcode), p 5..8 gives 2 (extended command), and p 9..12 gives 10 (check).
- R7: Sampling data 0 on the rising edge that brings the pointer to 8 extends the code to 36 bits. The field code then follows the pointer value p:

  | Pointer p | Field code |
  |---|---|
  | 5..8 | 2 |
  | 9..13 | 3 (reserved) |
  | 14..16 | 4 (pre-delay) |
  | 17..18 | 5 (pre-revision) |
  | 19..23 | 6 (pre-state) |
  | 24..25 | 7 (ready count) |
  | 26..27 | 8 (delay count) |
  | 28..32 | 9 (scan format) |
  | 33..36 | 10 |

- R8: When the pointer exceeds the code length, the block gives mode 2 (serial scan) and field 0, and raises tap_rst_o for exactly one system cycle.
- R9: An escape judged on the same rising edge that would complete an activation takes priority. A count of 8 gives mode 0 with no pulse. A count of 6 restarts activation at pointer 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| link_clk_i | input | 1 | Asynchronous link clock line |
| link_data_i | input | 1 | Asynchronous link data line (observed) |
| mode_o | output | 2 | 0 four-wire, 1 activation, 2 serial scan |
| field_o | output | 4 | Current activation field code, 0 outside activation |
| tap_rst_o | output | 1 | One-cycle pulse forcing TAP Test-Logic-Reset |

## Verification
The escape judgement and the activation completion both resolve on the same rising link-clock edge. The bench provokes this by advancing an activation to its last code bit and, in that same clock-high phase, toggling the data line 8 times or 6 times. For each case it then judges the mode, the field code and the count of reset pulses seen after the completing edge. The four-wire escape must suppress the pulse, and the activation escape must restart the field at the opcode instead of entering serial scan.

// File: rtl/esc_pkg.sv
package esc_pkg;

    typedef enum logic [1:0] {
        MODE_FOUR_WIRE = 2'd0,
        MODE_ACTIVATE  = 2'd1,
        MODE_SERIAL3   = 2'd2
    } link_mode_e;

    typedef enum logic [3:0] {
        FLD_NONE      = 4'd0,
        FLD_OPCODE    = 4'd1,
        FLD_EXTCMD    = 4'd2,
        FLD_RSVD      = 4'd3,
        FLD_PRE_DELAY = 4'd4,
        FLD_PRE_REV   = 4'd5,
        FLD_PRE_STATE = 4'd6,
        FLD_READY_CNT = 4'd7,
        FLD_DELAY_CNT = 4'd8,
        FLD_SCAN_FMT  = 4'd9,
        FLD_CHECK     = 4'd10
    } act_field_e;

    typedef enum logic [1:0] {
        ESC_NONE      = 2'd0,
        ESC_ACTIVATE  = 2'd1,
        ESC_FOUR_WIRE = 2'd2
    } esc_cmd_e;

    // Default code lengths and the pointer where extension is decided.
    localparam int SHORT_LEN_DEF = 12;
    localparam int LONG_LEN_DEF  = 36;
    localparam int EXTEND_AT_DEF = 8;

    // Lower bounds (exclusive) of each field, indexed by pointer value.
    localparam int B_EXTCMD      = 4;
    localparam int B_SHORT_CHECK = 8;
    localparam int B_RSVD        = 8;
    localparam int B_PRE_DELAY   = 13;
    localparam int B_PRE_REV     = 16;
    localparam int B_PRE_STATE   = 18;
    localparam int B_READY       = 23;
    localparam int B_DELAY       = 25;
    localparam int B_SCAN        = 27;
    localparam int B_LONG_CHECK  = 32;

    function automatic act_field_e field_at(input logic is_long, input logic [7:0] p);
        int v;
        v = int'(p);
        if (!is_long) begin
            if (v > B_SHORT_CHECK)    return FLD_CHECK;
            else if (v > B_EXTCMD)    return FLD_EXTCMD;
            else                      return FLD_OPCODE;
        end
        if (v > B_LONG_CHECK)         return FLD_CHECK;
        else if (v > B_SCAN)          return FLD_SCAN_FMT;
        else if (v > B_DELAY)         return FLD_DELAY_CNT;
        else if (v > B_READY)         return FLD_READY_CNT;
        else if (v > B_PRE_STATE)     return FLD_PRE_STATE;
        else if (v > B_PRE_REV)       return FLD_PRE_REV;
        else if (v > B_PRE_DELAY)     return FLD_PRE_DELAY;
        else if (v > B_RSVD)          return FLD_RSVD;
        else if (v > B_EXTCMD)        return FLD_EXTCMD;
        return FLD_OPCODE;
    endfunction

endpackage

// File: rtl/esc_sync.sv
module esc_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk_i) begin
            if (rst_i) chain <= '0;
            else       chain <= {chain[STAGES-2:0], d_i[b]};
        end
        assign q_o[b] = chain[STAGES-1];
    end
endmodule

// File: rtl/esc_edge_counter.sv
module esc_edge_counter
    import esc_pkg::*;
#(
    parameter int CNT_W      = 4,
    parameter int ACT_COUNT  = 6,
    parameter int FOUR_COUNT = 8
) (
    input  logic     clk_i,
    input  logic     rst_i,
    input  logic     lclk_s_i,
    input  logic     ldata_s_i,
    output logic     rise_o,
    output logic     bit_o,
    output esc_cmd_e esc_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] ACT_V   = CNT_W'(ACT_COUNT);
    localparam logic [CNT_W-1:0] FOUR_V  = CNT_W'(FOUR_COUNT);

    logic             lclk_q;
    logic             ldata_q;
    logic             data_edge;
    logic [CNT_W-1:0] cnt_q;

    assign rise_o    = lclk_s_i & ~lclk_q;
    assign data_edge = ldata_s_i ^ ldata_q;
    assign bit_o     = ldata_s_i;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            lclk_q  <= 1'b0;
            ldata_q <= 1'b0;
            cnt_q   <= '0;
        end else begin
            lclk_q  <= lclk_s_i;
            ldata_q <= ldata_s_i;
            if (rise_o)
                cnt_q <= '0;
            else if (data_edge && lclk_s_i && cnt_q != CNT_MAX)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        if (cnt_q >= FOUR_V)     esc_o = ESC_FOUR_WIRE;
        else if (cnt_q == ACT_V) esc_o = ESC_ACTIVATE;
        else                     esc_o = ESC_NONE;
    end
endmodule

// File: rtl/esc_act_fsm.sv
module esc_act_fsm
    import esc_pkg::*;
#(
    parameter int SHORT_LEN = SHORT_LEN_DEF,
    parameter int LONG_LEN  = LONG_LEN_DEF,
    parameter int EXTEND_AT = EXTEND_AT_DEF
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       rise_i,
    input  logic       bit_i,
    input  esc_cmd_e   esc_i,
    output logic [1:0] mode_o,
    output logic [3:0] field_o,
    output logic       tap_rst_o
);
    localparam int PTR_W = $clog2(LONG_LEN + 2);

    typedef enum logic [1:0] {
        ST_FOUR_WIRE = 2'd0,
        ST_ACT_SHORT = 2'd1,
        ST_ACT_LONG  = 2'd2,
        ST_SERIAL3   = 2'd3
    } st_e;

    st_e              state_q, state_d;
    logic [PTR_W-1:0] ptr_q, ptr_d, ptr_inc;
    logic             pulse_q, pulse_d;

    assign ptr_inc = ptr_q + 1'b1;

    // Transition logic
    always_comb begin
        state_d = state_q;
        ptr_d   = ptr_q;
        pulse_d = 1'b0;
        if (rise_i) begin
            if (esc_i == ESC_FOUR_WIRE) begin
                state_d = ST_FOUR_WIRE;
                ptr_d   = '0;
            end else if (esc_i == ESC_ACTIVATE) begin
                state_d = ST_ACT_SHORT;
                ptr_d   = PTR_W'(1);
            end else begin
                unique case (state_q)
                    ST_FOUR_WIRE, ST_SERIAL3: ;
                    ST_ACT_SHORT: begin
                        ptr_d = ptr_inc;
                        if (ptr_inc > PTR_W'(SHORT_LEN)) begin
                            state_d = ST_SERIAL3;
                            ptr_d   = '0;
                            pulse_d = 1'b1;
                        end else if (ptr_inc == PTR_W'(EXTEND_AT) && !bit_i) begin
                            state_d = ST_ACT_LONG;
                        end
                    end
                    ST_ACT_LONG: begin
                        ptr_d = ptr_inc;
                        if (ptr_inc > PTR_W'(LONG_LEN)) begin
                            state_d = ST_SERIAL3;
                            ptr_d   = '0;
                            pulse_d = 1'b1;
                        end
                    end
                    default: state_d = ST_FOUR_WIRE;
                endcase
            end
        end
    end

    // State register
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= ST_FOUR_WIRE;
            ptr_q   <= '0;
            pulse_q <= 1'b0;
        end else begin
            state_q <= state_d;
            ptr_q   <= ptr_d;
            pulse_q <= pulse_d;
        end
    end

    // Outputs
    always_comb begin
        tap_rst_o = pulse_q;
        unique case (state_q)
            ST_FOUR_WIRE: begin mode_o = MODE_FOUR_WIRE; field_o = FLD_NONE; end
            ST_ACT_SHORT: begin mode_o = MODE_ACTIVATE;  field_o = field_at(1'b0, 8'(ptr_q)); end
            ST_ACT_LONG:  begin mode_o = MODE_ACTIVATE;  field_o = field_at(1'b1, 8'(ptr_q)); end
            ST_SERIAL3:   begin mode_o = MODE_SERIAL3;   field_o = FLD_NONE; end
            default:      begin mode_o = MODE_FOUR_WIRE; field_o = FLD_NONE; end
        endcase
    end
endmodule

// File: rtl/link_escape_detect.sv
module link_escape_detect
    import esc_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int ESC_CNT_W   = 4,
    parameter int ESC_ACT     = 6,
    parameter int ESC_FOUR    = 8,
    parameter int SHORT_LEN   = SHORT_LEN_DEF,
    parameter int LONG_LEN    = LONG_LEN_DEF,
    parameter int EXTEND_AT   = EXTEND_AT_DEF
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       link_clk_i,
    input  logic       link_data_i,
    output logic [1:0] mode_o,
    output logic [3:0] field_o,
    output logic       tap_rst_o
);
    logic [1:0] line_sync;
    logic       lclk_rise;
    logic       sample_bit;
    esc_cmd_e   esc_cmd;

    esc_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   ({link_data_i, link_clk_i}),
        .q_o   (line_sync)
    );

    esc_edge_counter #(
        .CNT_W      (ESC_CNT_W),
        .ACT_COUNT  (ESC_ACT),
        .FOUR_COUNT (ESC_FOUR)
    ) u_cnt (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .lclk_s_i  (line_sync[0]),
        .ldata_s_i (line_sync[1]),
        .rise_o    (lclk_rise),
        .bit_o     (sample_bit),
        .esc_o     (esc_cmd)
    );

    esc_act_fsm #(
        .SHORT_LEN (SHORT_LEN),
        .LONG_LEN  (LONG_LEN),
        .EXTEND_AT (EXTEND_AT)
    ) u_fsm (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .rise_i    (lclk_rise),
        .bit_i     (sample_bit),
        .esc_i     (esc_cmd),
        .mode_o    (mode_o),
        .field_o   (field_o),
        .tap_rst_o (tap_rst_o)
    );
endmodule

// File: rtl/link_escape_detect_chk.sv
module link_escape_detect_chk (
    input logic       clk_i,
    input logic       rst_i,
    input logic       rise_i,
    input logic [1:0] mode_o,
    input logic [3:0] field_o,
    input logic       tap_rst_o
);
    // R8: reset pulse lasts a single cycle
    a_r8_pulse_single: assert property (@(posedge clk_i) disable iff (rst_i)
        tap_rst_o |=> !tap_rst_o);

    // R8: pulse only on the entry from activation into serial scan
    a_r8_pulse_on_entry: assert property (@(posedge clk_i) disable iff (rst_i)
        tap_rst_o |-> (mode_o == 2'd2 && $past(mode_o) == 2'd1));

    // R2: mode only moves after a synchronized rising link-clock edge
    a_r2_change_on_rise: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode_o != $past(mode_o)) |-> $past(rise_i));

    // R4: leaving four-wire leads only into activation
    a_r4_exit_four_wire: assert property (@(posedge clk_i) disable iff (rst_i)
        ($past(mode_o) == 2'd0 && mode_o != 2'd0) |-> mode_o == 2'd1);

    // R6: a field is reported exactly while activation runs
    a_r6_field_in_activation: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode_o == 2'd1) == (field_o != 4'd0));
endmodule

bind link_escape_detect link_escape_detect_chk u_chk (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .rise_i    (lclk_rise),
    .mode_o    (mode_o),
    .field_o   (field_o),
    .tap_rst_o (tap_rst_o)
);

// File: tb/link_escape_detect_test.sv
module link_escape_detect_test;
    localparam int CLK_P = 10;
    localparam int GAP   = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       link_clk = 1'b0;
    logic       link_data = 1'b0;
    logic [1:0] mode;
    logic [3:0] field;
    logic       tap_rst;

    int checks = 0;
    int fails  = 0;
    int pulses = 0;
    int run_len = 0;
    int max_run = 0;

    always #(CLK_P/2) clk = ~clk;

    link_escape_detect uut (
        .clk_i       (clk),
        .rst_i       (rst),
        .link_clk_i  (link_clk),
        .link_data_i (link_data),
        .mode_o      (mode),
        .field_o     (field),
        .tap_rst_o   (tap_rst)
    );

    always @(negedge clk) begin
        if (tap_rst) begin
            pulses++;
            run_len++;
            if (run_len > max_run) max_run = run_len;
        end else begin
            run_len = 0;
        end
    end

    typedef struct packed {
        logic [7:0] rep;
        logic [3:0] ntog;
        logic       d;
        logic [1:0] mode;
        logic [3:0] field;
        logic [1:0] npulse;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 47;
    localparam vec_t VECS [NV] = '{
        '{8'd1, 4'd0, 1'b1, 2'd0, 4'd0,  2'd0, 4'd1},  // R1 idle
        '{8'd1, 4'd3, 1'b1, 2'd0, 4'd0,  2'd0, 4'd5},  // R5
        '{8'd1, 4'd0, 1'b1, 2'd0, 4'd0,  2'd0, 4'd5},  // R5 count 3
        '{8'd1, 4'd6, 1'b1, 2'd0, 4'd0,  2'd0, 4'd2},  // R2 pending
        '{8'd1, 4'd0, 1'b1, 2'd1, 4'd1,  2'd0, 4'd4},  // R4 p1
        '{8'd3, 4'd0, 1'b1, 2'd1, 4'd1,  2'd0, 4'd6},  // R6 p4
        '{8'd1, 4'd0, 1'b1, 2'd1, 4'd2,  2'd0, 4'd6},  // p5
        '{8'd3, 4'd0, 1'b1, 2'd1, 4'd2,  2'd0, 4'd6},  // p8 data 1
        '{8'd1, 4'd0, 1'b1, 2'd1, 4'd10, 2'd0, 4'd6},  // p9
        '{8'd3, 4'd0, 1'b1, 2'd1, 4'd10, 2'd0, 4'd6},  // p12
        '{8'd1, 4'd0, 1'b1, 2'd2, 4'd0,  2'd1, 4'd8},  // R8 p13
        '{8'd1, 4'd7, 1'b1, 2'd2, 4'd0,  2'd0, 4'd5},
        '{8'd1, 4'd0, 1'b1, 2'd2, 4'd0,  2'd0, 4'd5},  // count 7
        '{8'd1, 4'd8, 1'b1, 2'd2, 4'd0,  2'd0, 4'd3},
        '{8'd1, 4'd0, 1'b1, 2'd0, 4'd0,  2'd0, 4'd3},  // R3
        '{8'd1, 4'd6, 1'b1, 2'd0, 4'd0,  2'd0, 4'd4},
        '{8'd1, 4'd0, 1'b1, 2'd1, 4'd1,  2'd0, 4'd4},  // p1
        '{8'd6, 4'd0, 1'b1, 2'd1, 4'd2,  2'd0, 4'd6},  // p7
        '{8'd1, 4'd0, 1'b0, 2'd1, 4'd2,  2'd0, 4'd7},  // R7 p8 data 0
        '{8'd1, 4'd0, 1'b1, 2'd1, 4'd3,  2'd0, 4'd7},  // p9
        '{8'd4, 4'd0, 1'b1, 2'd1, 4'd3,  2'd0, 4'd7},  // p13
        '{8'd1, 4'd0, 1'b1, 2'd1, 4'd4,  2'd0, 4'd7},  // p14
        '{8'd2, 4'd0, 1'b1, 2'd1, 4'd4,  2'd0, 4'd7},  // p16
        '{8'd1, 4'd0, 1'b1, 2'd1, 4'd5,  2'd0, 4'd7},  // p17
        '{8'd1, 4'd0, 1'b1, 2'd1, 4'd5,  2'd0, 4'd7},  // p18
        '{8'd1, 4'd0, 1'b1, 2'd1, 4'd6,  2'd0, 4'd7},  // p19
        '{8'd4, 4'd0, 1'b1, 2'd1, 4'd6,  2'd0, 4'd7},  // p23
        '{8'd1, 4'd0, 1'b1, 2'd1, 4'd7,  2'd0, 4'd7},  // p24
        '{8'd1, 4'd0, 1'b1, 2'd1, 4'd7,  2'd0, 4'd7},  // p25
        '{8'd1, 4'd0, 1'b1, 2'd1, 4'd8,  2'd0, 4'd7},  // p26
        '{8'd1, 4'd0, 1'b1, 2'd1, 4'd8,  2'd0, 4'd7},  // p27
        '{8'd1, 4'd0, 1'b1, 2'd1, 4'd9,  2'd0, 4'd7},  // p28
        '{8'd4, 4'd0, 1'b1, 2'd1, 4'd9,  2'd0, 4'd7},  // p32
        '{8'd1, 4'd0, 1'b1, 2'd1, 4'd10, 2'd0, 4'd7},  // p33
        '{8'd3, 4'd0, 1'b1, 2'd1, 4'd10, 2'd0, 4'd7},  // p36
        '{8'd1, 4'd0, 1'b1, 2'd2, 4'd0,  2'd1, 4'd8},  // p37
        '{8'd1, 4'd8, 1'b1, 2'd2, 4'd0,  2'd0, 4'd3},
        '{8'd1, 4'd6, 1'b1, 2'd0, 4'd0,  2'd0, 4'd3},  // four-wire, 6 pending
        '{8'd1, 4'd0, 1'b1, 2'd1, 4'd1,  2'd0, 4'd4},  // p1
        '{8'd10,4'd0, 1'b1, 2'd1, 4'd10, 2'd0, 4'd6},  // p11
        '{8'd1, 4'd8, 1'b1, 2'd1, 4'd10, 2'd0, 4'd9},  // R9 p12, 8 pending
        '{8'd1, 4'd0, 1'b1, 2'd0, 4'd0,  2'd0, 4'd9},  // escape wins, no pulse
        '{8'd1, 4'd6, 1'b1, 2'd0, 4'd0,  2'd0, 4'd4},
        '{8'd11,4'd0, 1'b1, 2'd1, 4'd10, 2'd0, 4'd6},  // p11
        '{8'd1, 4'd6, 1'b1, 2'd1, 4'd10, 2'd0, 4'd9},  // p12, 6 pending
        '{8'd1, 4'd0, 1'b1, 2'd1, 4'd1,  2'd0, 4'd9},  // restart p1
        '{8'd4, 4'd0, 1'b1, 2'd1, 4'd2,  2'd0, 4'd6}   // p5
    };

    task automatic check(input int req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL R%0d %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wait_gap();
        repeat (GAP) @(negedge clk);
    endtask

    task automatic step(input int ntog, input logic d);
        @(negedge clk);
        link_data = d;
        wait_gap();
        link_clk = 1'b1;
        wait_gap();
        for (int i = 0; i < ntog; i++) begin
            link_data = ~link_data;
            wait_gap();
        end
        link_clk = 1'b0;
        wait_gap();
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(CLK_P * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        check(1, "reset mode", int'(mode), 0);
        check(1, "reset field", int'(field), 0);
        check(1, "reset pulse", int'(tap_rst), 0);
        rst = 1'b0;

        for (int v = 0; v < NV; v++) begin
            int p0;
            p0 = pulses;
            for (int r = 0; r < int'(VECS[v].rep); r++)
                step(int'(VECS[v].ntog), VECS[v].d);
            check(int'(VECS[v].req), $sformatf("vec %0d mode", v), int'(mode), int'(VECS[v].mode));
            check(int'(VECS[v].req), $sformatf("vec %0d field", v), int'(field), int'(VECS[v].field));
            check(int'(VECS[v].req), $sformatf("vec %0d pulses", v), pulses - p0, int'(VECS[v].npulse));
        end

        // R2: eight toggles in the low phase must not count (pointer 5 -> 6)
        for (int i = 0; i < 8; i++) begin
            link_data = ~link_data;
            wait_gap();
        end
        step(0, 1'b1);
        check(2, "low-phase toggles mode", int'(mode), 1);
        check(2, "low-phase toggles field", int'(field), 2);

        // R8: every reset pulse was one cycle wide
        check(8, "pulse width", max_run, 1);

        // R1: reset in mid-activation
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(1, "mid reset mode", int'(mode), 0);
        check(1, "mid reset field", int'(field), 0);
        rst = 1'b0;
        step(0, 1'b1);
        check(1, "after reset mode", int'(mode), 0);

        finish_run();
    end
endmodule